// File: doc/BRIEF.md
# Critical-Word-First Line Refill Buffer

This block sits between a memory port that returns a cache-line refill one word per beat and the cache that will install the line. A refill opens with a start request that names the word offset the missing load wanted and the tag of that load. Memory then delivers the line beginning at that word and wrapping around the end of the line. Each beat is placed in its proper slot of a line buffer. The waiting load is answered as soon as its word appears, without waiting for the whole line (early restart).

While the refill is still arriving, further loads to the same line can be queued in a small table of waiting slots. A load whose word has already been written is answered straight from the buffer. A load whose word is still missing is answered when that word's beat lands. When the last beat is written, a one-cycle pulse announces that the whole line is ready for install. The line stays readable until the next refill starts.

Fill start, beats, secondary loads and responses are all valid/ready streams, and a transfer happens on any cycle where both are high. Only `beat_ready` and `ld_ready` depend on the block's own state. The response stream honours back-pressure: while `rsp_ready` is low, the offered response stays frozen. Waiting loads then stay in their slots.

Top module: `cwf_fill_buf`

## Requirements
- R1: After reset, `fill_ready` is 1, and `beat_ready`, `ld_ready`, `rsp_valid`, `line_done` and `line_full` are all 0.
- R2: `fill_ready` is 1 only when no refill is in progress, no load slot is occupied and no response is being offered. A start presented while `fill_ready` is 0 has no effect.
- R3: Beat number k of a refill (counting from 0) is written to word offset (start offset + k) modulo the words per line. Word w of `line_data` occupies bits [w*DATA_W +: DATA_W].
- R4: The refill's own load is answered in the cycle right after the first beat handshake, with that beat's data and the start request's tag.
- R5: A secondary load whose word is already in the buffer becomes eligible at the clock edge that accepts it, and its response is offered one edge later if the output is free and it wins arbitration.
- R6: A secondary load whose word is still missing waits and is answered in the cycle right after that word's beat handshake, if the output is free and it wins arbitration.
- R7: The refill's own load takes slot 0, and each secondary load takes the lowest free slot. Among eligible slots the lowest index is answered first. `ld_ready` is 1 only while a refill is in progress and at least one slot is free.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_id` and `rsp_data` hold their values.
- R9: `line_done` is high for exactly one cycle, the cycle after the last beat handshake. `line_full` is high from then until the next refill starts, and `beat_ready` drops at the same time.
- R10: Accepting a refill start clears every word-valid flag, so `line_full` reads 0 in the next cycle, and `beat_ready` rises in that same cycle.
- R11: The line size is LINE_BYTES (64 by default, also 32 or 16), and `line_data` is LINE_BYTES*8 bits wide.
- R12: A beat presented while `beat_ready` is 0 has no effect on `line_data`, `line_done` or `line_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Refill start request offered |
| fill_ready | output | 1 | Refill start can be accepted |
| fill_ofs | input | OFS_W | Word offset of the missing load |
| fill_id | input | ID_W | Tag of the missing load |
| beat_valid | input | 1 | Refill beat offered |
| beat_ready | output | 1 | Beat can be accepted (refill in progress) |
| beat_data | input | DATA_W | Beat payload |
| ld_valid | input | 1 | Secondary load offered |
| ld_ready | output | 1 | Secondary load can be accepted |
| ld_ofs | input | OFS_W | Word offset of the secondary load |
| ld_id | input | ID_W | Tag of the secondary load |
| rsp_valid | output | 1 | Load response offered |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_id | output | ID_W | Tag of the answered load |
| rsp_data | output | DATA_W | Word returned to the load |
| line_done | output | 1 | One-cycle pulse when the line is complete |
| line_full | output | 1 | Every word of the line is present |
| line_data | output | LINE_BYTES*8 | Whole line for install |

## Verification
A wrong beat counter or start offset puts a word in the wrong slot. The bench sees that once the line completes, as a mismatched word in `line_data`. If the wrap or count lets a response be served from the wrong slot, `rsp_data` is wrong in the very cycle it is offered. A corrupted valid bitmap or slot table shows within one cycle as a response that comes early, late or with the wrong tag. If the table fails to empty, `fill_ready` stays low and the next refill stalls. A stuck beat counter shows as `line_done` missing or `beat_ready` staying high past the last beat. The bench runs a behavioural model beside the block, so each of these faults is flagged in the first cycle it reaches a port.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

  // Refill sequencer phase
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_FILL = 1'b1
  } phase_e;

endpackage

// File: rtl/cwf_beat_seq.sv
module cwf_beat_seq
  import cwf_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int OFS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OFS_W-1:0] start_ofs,
  input  logic             beat_valid,
  output logic             busy,
  output logic             beat_fire,
  output logic             first_fire,
  output logic [OFS_W-1:0] wr_ofs,
  output logic             line_done
);

  localparam logic [OFS_W-1:0] LAST = OFS_W'(WORDS - 1);

  phase_e           ph;
  logic [OFS_W-1:0] cnt;
  logic [OFS_W-1:0] crit;
  logic             done_q;
  logic             last;

  assign busy       = (ph == PH_FILL);
  assign beat_fire  = beat_valid && busy;
  assign first_fire = beat_fire && (cnt == '0);
  // word count is a power of two, so the sum wraps around the line
  assign wr_ofs     = crit + cnt;
  assign last       = (cnt == LAST);
  assign line_done  = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      crit   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        ph   <= PH_FILL;
        cnt  <= '0;
        crit <= start_ofs;
      end else if (beat_fire) begin
        cnt <= cnt + 1'b1;
        if (last) begin
          ph     <= PH_IDLE;
          done_q <= 1'b1;
        end
      end
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);

  // R3
  ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !beat_fire && !start) |=> $stable(wr_ofs));

endmodule

// File: rtl/cwf_line_store.sv
module cwf_line_store #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 64,
  parameter int OFS_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    wr_en,
  input  logic [OFS_W-1:0]        wr_ofs,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [WORDS-1:0]        vbits,
  output logic [WORDS*DATA_W-1:0] line_flat,
  output logic                    line_full
);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic              vld_q;
    logic              hit;

    assign hit = wr_en && (wr_ofs == OFS_W'(w));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        if (clr) begin
          vld_q <= 1'b0;
        end else if (hit) begin
          vld_q <= 1'b1;
        end
        if (hit) begin
          word_q <= wr_data;
        end
      end
    end

    assign vbits[w]                        = vld_q;
    assign line_flat[w*DATA_W +: DATA_W]   = word_q;
  end

  assign line_full = &vbits;

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !line_full);

  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_full && !clr) |=> line_full);

endmodule

// File: rtl/cwf_load_table.sv
module cwf_load_table #(
  parameter int SLOTS  = 4,
  parameter int WORDS  = 8,
  parameter int DATA_W = 64,
  parameter int OFS_W  = 3,
  parameter int ID_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    crit_load,
  input  logic [OFS_W-1:0]        crit_ofs,
  input  logic [ID_W-1:0]         crit_id,
  input  logic                    ld_fire,
  input  logic [OFS_W-1:0]        ld_ofs,
  input  logic [ID_W-1:0]         ld_id,
  input  logic [WORDS-1:0]        vbits,
  input  logic [WORDS*DATA_W-1:0] line_flat,
  input  logic                    beat_fire,
  input  logic [OFS_W-1:0]        beat_ofs,
  input  logic [DATA_W-1:0]       beat_data,
  input  logic                    rsp_ready,
  output logic                    rsp_valid,
  output logic [ID_W-1:0]         rsp_id,
  output logic [DATA_W-1:0]       rsp_data,
  output logic                    any_pend,
  output logic                    slot_free
);

  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOTS-1:0]  pend;
  logic [OFS_W-1:0]  sofs [SLOTS];
  logic [ID_W-1:0]   sid  [SLOTS];
  logic [SLOTS-1:0]  elig;
  logic [SLOT_W-1:0] sel;
  logic              found;
  logic [SLOT_W-1:0] fidx;
  logic [OFS_W-1:0]  rd_ofs;
  logic [DATA_W-1:0] pick;
  logic              load_en;

  for (genvar i = 0; i < SLOTS; i++) begin : g_elig
    assign elig[i] = pend[i] &&
                     (vbits[sofs[i]] || (beat_fire && (beat_ofs == sofs[i])));
  end

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        sel   = SLOT_W'(i);
      end
    end
  end

  always_comb begin
    fidx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!pend[i]) begin
        fidx = SLOT_W'(i);
      end
    end
  end

  assign rd_ofs    = sofs[sel];
  assign pick      = vbits[rd_ofs] ? line_flat[rd_ofs*DATA_W +: DATA_W] : beat_data;
  assign load_en   = !rsp_valid || rsp_ready;
  assign any_pend  = |pend;
  assign slot_free = ~&pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= '0;
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_data  <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        sofs[i] <= '0;
        sid[i]  <= '0;
      end
    end else begin
      if (load_en) begin
        if (found) begin
          rsp_valid <= 1'b1;
          rsp_id    <= sid[sel];
          rsp_data  <= pick;
          pend[sel] <= 1'b0;
        end else begin
          rsp_valid <= 1'b0;
        end
      end
      if (ld_fire) begin
        pend[fidx] <= 1'b1;
        sofs[fidx] <= ld_ofs;
        sid[fidx]  <= ld_id;
      end
      if (crit_load) begin
        pend[0] <= 1'b1;
        sofs[0] <= crit_ofs;
        sid[0]  <= crit_id;
      end
    end
  end

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_id) && $stable(rsp_data)));

  // R7
  slot_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fire && !crit_load) |=> ($countones(pend) >= 1));

endmodule

// File: rtl/cwf_fill_buf.sv
module cwf_fill_buf #(
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8,
  parameter int SLOTS      = 4,
  parameter int ID_W       = 4,
  localparam int WORDS     = LINE_BYTES / WORD_BYTES,
  localparam int DATA_W    = WORD_BYTES * 8,
  localparam int OFS_W     = $clog2(WORDS),
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [OFS_W-1:0]  fill_ofs,
  input  logic [ID_W-1:0]   fill_id,
  input  logic              beat_valid,
  output logic              beat_ready,
  input  logic [DATA_W-1:0] beat_data,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [OFS_W-1:0]  ld_ofs,
  input  logic [ID_W-1:0]   ld_id,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ID_W-1:0]   rsp_id,
  output logic [DATA_W-1:0] rsp_data,
  output logic              line_done,
  output logic              line_full,
  output logic [LINE_W-1:0] line_data
);

  logic             busy;
  logic             beat_fire;
  logic             first_fire;
  logic [OFS_W-1:0] wr_ofs;
  logic [WORDS-1:0] vbits;
  logic             any_pend;
  logic             slot_free;
  logic             fill_fire;
  logic             ld_fire;

  assign fill_ready = !busy && !any_pend && !rsp_valid;
  assign fill_fire  = fill_valid && fill_ready;
  assign beat_ready = busy;
  assign ld_ready   = busy && slot_free;
  assign ld_fire    = ld_valid && ld_ready;

  cwf_beat_seq #(
    .WORDS (WORDS),
    .OFS_W (OFS_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (fill_fire),
    .start_ofs  (fill_ofs),
    .beat_valid (beat_valid),
    .busy       (busy),
    .beat_fire  (beat_fire),
    .first_fire (first_fire),
    .wr_ofs     (wr_ofs),
    .line_done  (line_done)
  );

  cwf_line_store #(
    .WORDS  (WORDS),
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (fill_fire),
    .wr_en     (beat_fire),
    .wr_ofs    (wr_ofs),
    .wr_data   (beat_data),
    .vbits     (vbits),
    .line_flat (line_data),
    .line_full (line_full)
  );

  cwf_load_table #(
    .SLOTS  (SLOTS),
    .WORDS  (WORDS),
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W),
    .ID_W   (ID_W)
  ) u_tab (
    .clk       (clk),
    .rst_n     (rst_n),
    .crit_load (fill_fire),
    .crit_ofs  (fill_ofs),
    .crit_id   (fill_id),
    .ld_fire   (ld_fire),
    .ld_ofs    (ld_ofs),
    .ld_id     (ld_id),
    .vbits     (vbits),
    .line_flat (line_data),
    .beat_fire (beat_fire),
    .beat_ofs  (wr_ofs),
    .beat_data (beat_data),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_id    (rsp_id),
    .rsp_data  (rsp_data),
    .any_pend  (any_pend),
    .slot_free (slot_free)
  );

  // R4
  early_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_fire |=> (rsp_valid && (rsp_data == $past(beat_data))));

  // R9
  done_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> (line_full && !beat_ready));

endmodule

// File: tb/cwf_fill_buf_bench.sv
module cwf_fill_buf_bench;

  localparam int LB  = 64;
  localparam int WB  = 8;
  localparam int NS  = 4;
  localparam int IW  = 4;
  localparam int W   = LB / WB;
  localparam int DW  = WB * 8;
  localparam int OW  = $clog2(W);
  localparam int LW  = LB * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fill_valid = 1'b0;
  logic          fill_ready;
  logic [OW-1:0] fill_ofs = '0;
  logic [IW-1:0] fill_id = '0;
  logic          beat_valid = 1'b0;
  logic          beat_ready;
  logic [DW-1:0] beat_data = '0;
  logic          ld_valid = 1'b0;
  logic          ld_ready;
  logic [OW-1:0] ld_ofs = '0;
  logic [IW-1:0] ld_id = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [IW-1:0] rsp_id;
  logic [DW-1:0] rsp_data;
  logic          line_done;
  logic          line_full;
  logic [LW-1:0] line_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cwf_fill_buf #(.LINE_BYTES(LB), .WORD_BYTES(WB), .SLOTS(NS), .ID_W(IW)) u_cwf_fill_buf (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_ofs(fill_ofs), .fill_id(fill_id),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_data(beat_data),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_ofs(ld_ofs), .ld_id(ld_id),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id), .rsp_data(rsp_data),
    .line_done(line_done), .line_full(line_full), .line_data(line_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [DW-1:0] m_line [W];
  bit            m_vb   [W];
  bit            m_pend [NS];
  int            m_pofs [NS];
  int            m_pid  [NS];
  bit            m_busy, m_rv, m_done;
  int            m_cnt, m_crit, m_rid;
  logic [DW-1:0] m_rdata;
  bit            t_bf, t_lf, t_ff, t_any;
  int            t_bofs, t_sel, t_fr;

  function automatic bit m_full();
    for (int i = 0; i < W; i++) if (!m_vb[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit m_anypend();
    for (int i = 0; i < NS; i++) if (m_pend[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit m_free();
    for (int i = 0; i < NS; i++) if (!m_pend[i]) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_rv = 0; m_done = 0; m_cnt = 0; m_crit = 0; m_rid = 0; m_rdata = '0;
      for (int i = 0; i < W; i++) begin m_vb[i] = 0; m_line[i] = '0; end
      for (int i = 0; i < NS; i++) begin m_pend[i] = 0; m_pofs[i] = 0; m_pid[i] = 0; end
    end else begin
      t_any  = m_anypend();
      t_ff   = fill_valid && !m_busy && !t_any && !m_rv;
      t_bf   = beat_valid && m_busy;
      t_bofs = (m_crit + m_cnt) % W;
      t_fr   = -1;
      for (int i = NS - 1; i >= 0; i--) if (!m_pend[i]) t_fr = i;
      t_lf   = ld_valid && m_busy && (t_fr >= 0);
      t_sel  = -1;
      for (int i = NS - 1; i >= 0; i--)
        if (m_pend[i] && (m_vb[m_pofs[i]] || (t_bf && t_bofs == m_pofs[i]))) t_sel = i;
      if (!m_rv || rsp_ready) begin
        if (t_sel >= 0) begin
          m_rv    = 1;
          m_rid   = m_pid[t_sel];
          m_rdata = m_vb[m_pofs[t_sel]] ? m_line[m_pofs[t_sel]] : beat_data;
          m_pend[t_sel] = 0;
        end else begin
          m_rv = 0;
        end
      end
      if (t_lf) begin
        m_pend[t_fr] = 1; m_pofs[t_fr] = int'(ld_ofs); m_pid[t_fr] = int'(ld_id);
      end
      m_done = 0;
      if (t_bf) begin
        m_line[t_bofs] = beat_data;
        m_vb[t_bofs]   = 1;
        if (m_cnt == W - 1) begin m_busy = 0; m_done = 1; end
        m_cnt++;
      end
      if (t_ff) begin
        m_busy = 1; m_cnt = 0; m_crit = int'(fill_ofs);
        for (int i = 0; i < W; i++) m_vb[i] = 0;
        m_pend[0] = 1; m_pofs[0] = int'(fill_ofs); m_pid[0] = int'(fill_id);
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cycles++;
      check(fill_ready == (!m_busy && !m_anypend() && !m_rv), "R2", "fill_ready",
            fill_ready, (!m_busy && !m_anypend() && !m_rv));
      check(beat_ready == m_busy, "R10", "beat_ready", beat_ready, m_busy);
      check(ld_ready == (m_busy && m_free()), "R7", "ld_ready", ld_ready, (m_busy && m_free()));
      check(rsp_valid == m_rv, "R6", "rsp_valid", rsp_valid, m_rv);
      if (m_rv) begin
        check(rsp_id == IW'(m_rid), "R5", "rsp_id", rsp_id, m_rid);
        check(rsp_data == m_rdata, "R8", "rsp_data", rsp_data, m_rdata);
      end
      check(line_done == m_done, "R9", "line_done", line_done, m_done);
      check(line_full == m_full(), "R9", "line_full", line_full, m_full());
      if (m_full()) begin
        for (int w = 0; w < W; w++)
          check(line_data[w*DW +: DW] == m_line[w], "R3", "line word",
                line_data[w*DW +: DW], m_line[w]);
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    logic [LW-1:0] snap;
    // R11: line width follows LINE_BYTES
    check($bits(line_data) == LB * 8, "R11", "line width", $bits(line_data), LB * 8);

    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state
    check(fill_ready == 1'b1, "R1", "fill_ready", fill_ready, 1);
    check(beat_ready == 1'b0, "R1", "beat_ready", beat_ready, 0);
    check(ld_ready == 1'b0, "R1", "ld_ready", ld_ready, 0);
    check(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
    check(line_done == 1'b0 && line_full == 1'b0, "R1", "done/full", {line_done, line_full}, 0);

    // Test A: full refill starting at offset 5
    fill_valid = 1; fill_ofs = 3'd5; fill_id = 4'd3; rsp_ready = 1;
    tick();
    fill_valid = 0;
    check(beat_ready == 1'b1, "R10", "beat_ready after start", beat_ready, 1);
    check(line_full == 1'b0, "R10", "line_full after start", line_full, 0);
    for (int k = 0; k < W; k++) begin
      beat_valid = 1; beat_data = 64'hA000 + DW'(k);
      tick();
      if (k == 0) begin
        check(rsp_valid && rsp_id == 4'd3 && rsp_data == 64'hA000, "R4", "critical response",
              rsp_data, 64'hA000);
      end
    end
    beat_valid = 0;
    check(line_done == 1'b1, "R9", "done pulse", line_done, 1);
    tick();
    check(line_done == 1'b0 && line_full == 1'b1, "R9", "done once, full held",
          {line_done, line_full}, 2'b01);
    for (int k = 0; k < W; k++)
      check(line_data[((5 + k) % W)*DW +: DW] == 64'hA000 + DW'(k), "R3", "wrap slot",
            line_data[((5 + k) % W)*DW +: DW], 64'hA000 + k);

    // R12: beats with no refill in progress are ignored
    snap = line_data;
    beat_valid = 1; beat_data = 64'hDEAD;
    repeat (3) tick();
    beat_valid = 0;
    check(line_data == snap && line_full && !line_done, "R12", "idle beats ignored",
          line_data[DW-1:0], snap[DW-1:0]);

    // Test B: secondary loads, present and missing words
    fill_valid = 1; fill_ofs = 3'd2; fill_id = 4'd1;
    tick();
    fill_valid = 0;
    beat_valid = 1; beat_data = 64'hB0;
    tick();
    beat_valid = 0;
    check(rsp_valid && rsp_id == 4'd1, "R4", "critical id", rsp_id, 1);
    tick();
    ld_valid = 1; ld_ofs = 3'd2; ld_id = 4'd7;
    tick();
    ld_valid = 0;
    check(rsp_valid == 1'b0, "R5", "not yet offered", rsp_valid, 0);
    tick();
    check(rsp_valid && rsp_id == 4'd7 && rsp_data == 64'hB0, "R5", "present word", rsp_data, 64'hB0);
    ld_valid = 1; ld_ofs = 3'd3; ld_id = 4'd8;
    tick();
    ld_valid = 0;
    tick();
    check(rsp_valid == 1'b0, "R6", "waits for beat", rsp_valid, 0);
    beat_valid = 1; beat_data = 64'hB1;
    tick();
    beat_valid = 0;
    check(rsp_valid && rsp_id == 4'd8 && rsp_data == 64'hB1, "R6", "answered on beat", rsp_data, 64'hB1);

    // R8: back-pressure
    tick();
    rsp_ready = 0;
    ld_valid = 1; ld_ofs = 3'd2; ld_id = 4'd4;
    tick();
    ld_valid = 0;
    tick();
    check(rsp_valid && rsp_id == 4'd4, "R8", "offered", rsp_id, 4);
    tick();
    tick();
    check(rsp_valid && rsp_id == 4'd4 && rsp_data == 64'hB0, "R8", "held", rsp_data, 64'hB0);
    rsp_ready = 1;
    tick();

    // R7: fill all slots with loads waiting on offset 7 (beat 5)
    for (int i = 0; i < NS; i++) begin
      ld_valid = 1; ld_ofs = 3'd7; ld_id = IW'(10 + i);
      tick();
    end
    ld_valid = 0;
    check(ld_ready == 1'b0, "R7", "table full", ld_ready, 0);
    for (int k = 2; k < W; k++) begin
      beat_valid = 1; beat_data = 64'hB0 + DW'(k);
      tick();
    end
    beat_valid = 0;
    for (int i = 0; i < NS + 2; i++) tick();

    // random traffic compared against the model
    for (int c = 0; c < 4000; c++) begin
      fill_valid = ($urandom_range(0, 9) < 3);
      fill_ofs   = OW'($urandom_range(0, W - 1));
      fill_id    = IW'($urandom_range(0, 15));
      beat_valid = ($urandom_range(0, 9) < 6);
      beat_data  = {$urandom, $urandom};
      ld_valid   = ($urandom_range(0, 9) < 4);
      ld_ofs     = OW'($urandom_range(0, W - 1));
      ld_id      = IW'($urandom_range(0, 15));
      rsp_ready  = ($urandom_range(0, 9) < 7);
      tick();
    end
    fill_valid = 0; beat_valid = 0; ld_valid = 0; rsp_ready = 1;
    repeat (4) tick();

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule